// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a synchronous burst memory. Two independent load strobes are provided, one for the processor side and one for the controller side. When either strobe is high at a clock edge, the block captures a complete start address and the burst ordering selected on the mode pin. From then on, each clock edge with the advance input high steps a small wraparound burst counter. The low address bits are formed from the captured start offset and that counter. The upper bits stay at the captured value until the next load.

Two orderings are available. In linear order, the low bits count upward from the start offset and wrap. In interleaved order, the low bits are the start offset XORed with the burst count. With the default counter width of two, a burst covers four addresses and then returns to its starting address. The memory array, write control and chip-select decoding belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `mem_addr` and `burst_pos` are zero.
- R2: A clock edge with `ld_proc` or `ld_ctrl` high (either one, or both) loads `start_addr`. In the following cycle `mem_addr` equals the loaded address and `burst_pos` is 0.
- R3: A clock edge with `adv` high and both strobes low increments `burst_pos` by one, modulo 2^BURST_W (4 by default).
- R4: A clock edge with `adv` and both strobes low leaves `mem_addr` and `burst_pos` unchanged.
- R5: When `order_sel` was 0 at the load edge (linear order), the low BURST_W bits of `mem_addr` equal (start offset + `burst_pos`) mod 2^BURST_W.
- R6: When `order_sel` was 1 at the load edge (interleaved order), the low BURST_W bits of `mem_addr` equal the start offset XOR `burst_pos`.
- R7: Between loads, bits above the low BURST_W bits of `mem_addr` stay equal to the captured start address.
- R8: A load strobe in the middle of a burst takes priority over `adv`. It reloads the address and resets `burst_pos` to 0.
- R9: After 2^BURST_W advances, `mem_addr` returns to the loaded start address.
- R10: `order_sel` is sampled only at a load edge. Changing it mid-burst has no effect on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_proc | input | 1 | Processor-side load strobe, active high |
| ld_ctrl | input | 1 | Controller-side load strobe, active high |
| adv | input | 1 | Advance to the next burst address, active high |
| order_sel | input | 1 | Burst order for the next load: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Start address captured on a load |
| mem_addr | output | ADDR_W | Current burst address |
| burst_pos | output | BURST_W | Number of advances since the last load, wrapping |

## Verification
The assertions assume every input is a defined 0 or 1 at each rising edge. They also assume that a load is recognised from either strobe alone, with no qualifying condition. The stimulus changes inputs only on falling edges and drives a full value every cycle, so no unknown ever reaches a sampled edge. The sweep covers both orderings, every start offset, both strobes and two different upper-address patterns. It also includes hold cycles, a reload in the middle of a burst, and an order change in the middle of a burst, so each assumption is exercised with legal input values only.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               order_sel,
    output logic [ADDR_W-1:0]  base_q_o,
    output logic [BURST_W-1:0] cnt_q_o,
    output order_e             order_q_o
);
    localparam logic [BURST_W-1:0] CNT_ONE = BURST_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        order_e             order;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            // a load wins over advance (R8); order is captured only here (R10)
            state_d.base  = start_addr;
            state_d.cnt   = '0;
            state_d.order = order_e'(order_sel);
        end else if (adv) begin
            state_d.cnt = state_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{base: '0, cnt: '0, order: ORDER_LINEAR};
        end else begin
            state_q <= state_d;
        end
    end

    assign base_q_o  = state_q.base;
    assign cnt_q_o   = state_q.cnt;
    assign order_q_o = state_q.order;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] offset,
    input  logic [BURST_W-1:0] cnt,
    input  order_e             order,
    output logic [BURST_W-1:0] low_bits
);
    logic [BURST_W-1:0] lin_bits;
    logic [BURST_W-1:0] ilv_bits;

    // sum truncates to BURST_W bits, giving the wraparound
    assign lin_bits = offset + cnt;

    genvar gi;
    generate
        for (gi = 0; gi < BURST_W; gi++) begin : g_ilv
            assign ilv_bits[gi] = offset[gi] ^ cnt[gi];
        end
    endgenerate

    always_comb begin
        unique case (order)
            ORDER_INTERLEAVED: low_bits = ilv_bits;
            default:           low_bits = lin_bits;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_proc,
    input  logic               ld_ctrl,
    input  logic               adv,
    input  logic               order_sel,
    input  logic [ADDR_W-1:0]  start_addr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BURST_W-1:0] burst_pos
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic               load;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    order_e             order_q;
    logic [BURST_W-1:0] low_bits;

    assign load = ld_proc | ld_ctrl;

    burst_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .adv        (adv),
        .start_addr (start_addr),
        .order_sel  (order_sel),
        .base_q_o   (base_q),
        .cnt_q_o    (cnt_q),
        .order_q_o  (order_q)
    );

    burst_order_map #(.BURST_W(BURST_W)) u_map (
        .offset   (base_q[BURST_W-1:0]),
        .cnt      (cnt_q),
        .order    (order_q),
        .low_bits (low_bits)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign mem_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
        end else begin : g_nohi
            assign mem_addr = low_bits;
        end
    endgenerate

    assign burst_pos = cnt_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_proc,
    input logic               ld_ctrl,
    input logic               adv,
    input logic [ADDR_W-1:0]  start_addr,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [BURST_W-1:0] burst_pos
);
    localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_proc || ld_ctrl) |=> (mem_addr == $past(start_addr) && burst_pos == '0)); // R2

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_proc && !ld_ctrl && adv) |=> (burst_pos == $past(burst_pos) + ONE)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_proc && !ld_ctrl && !adv) |=> ($stable(mem_addr) && $stable(burst_pos))); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_proc && !ld_ctrl) |=> ($stable(mem_addr[ADDR_W-1:BURST_W]))); // R7

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_proc || ld_ctrl) && adv) |=> (burst_pos == '0)); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_proc    (ld_proc),
    .ld_ctrl    (ld_ctrl),
    .adv        (adv),
    .start_addr (start_addr),
    .mem_addr   (mem_addr),
    .burst_pos  (burst_pos)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int AW = 18;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_proc = 1'b0;
    logic          ld_ctrl = 1'b0;
    logic          adv = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] burst_pos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_proc(ld_proc), .ld_ctrl(ld_ctrl),
        .adv(adv), .order_sel(order_sel), .start_addr(start_addr),
        .mem_addr(mem_addr), .burst_pos(burst_pos)
    );

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s,
                                                  input bit ilv, input int k);
        int off;
        int low;
        off = int'(s[BW-1:0]);
        low = ilv ? (off ^ (k % 4)) : ((off + k) % 4);
        return {s[AW-1:BW], BW'(low)};
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] exp_a, input int exp_p);
        checks++;
        if (mem_addr !== exp_a || burst_pos !== BW'(exp_p)) begin
            errors++;
            $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d",
                     req, mem_addr, burst_pos, exp_a, exp_p);
        end
    endtask

    // apply inputs at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic cyc(input bit lp, input bit lc, input bit a, input bit m,
                       input logic [AW-1:0] s);
        ld_proc = lp; ld_ctrl = lc; adv = a; order_sel = m; start_addr = s;
        @(negedge clk);
    endtask

    initial begin
        logic [AW-1:0] s;
        @(negedge clk);
        chk("R1", '0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, '1);
        chk("R1", '0, 0);

        // full sweep: both orders, every offset, both strobes, two upper patterns
        for (int m = 0; m < 2; m++) begin
            for (int off = 0; off < 4; off++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int up = 0; up < 2; up++) begin
                        s = {(up == 0) ? 16'h5A3C : 16'hC3A5, 2'(off)};
                        cyc(st == 0, st == 1, 0, m[0], s);
                        chk("R2", s, 0);
                        for (int k = 1; k <= 4; k++) begin
                            cyc(0, 0, 1, m[0], ~s);
                            chk(m == 0 ? "R5/R7" : "R6/R7", expect_addr(s, m[0], k), k % 4);
                        end
                        chk("R9", s, 0);
                        cyc(0, 0, 1, m[0], ~s);
                        chk("R3", expect_addr(s, m[0], 1), 1);
                        cyc(0, 0, 0, m[0], ~s);
                        chk("R4", expect_addr(s, m[0], 1), 1);
                    end
                end
            end
        end

        // mid-burst reload with advance high, both strobes together
        s = 18'h2_1235;
        cyc(1, 0, 0, 1, s);
        cyc(0, 0, 1, 1, '0);
        cyc(0, 0, 1, 1, '0);
        chk("R6", expect_addr(s, 1, 2), 2);
        cyc(1, 1, 1, 0, 18'h0_0F02);
        chk("R8", 18'h0_0F02, 0);

        // order change mid-burst has no effect
        s = 18'h1_0003;
        cyc(0, 1, 0, 0, s);
        cyc(0, 0, 1, 1, '0);
        chk("R10", expect_addr(s, 0, 1), 1);
        cyc(0, 0, 1, 1, '0);
        chk("R10", expect_addr(s, 0, 2), 2);
        cyc(0, 0, 0, 0, '0);
        chk("R10", expect_addr(s, 0, 2), 2);

        // reset mid-burst
        rst_n = 1'b0;
        cyc(0, 0, 1, 1, '0);
        chk("R1", '0, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule